// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a small register window through which a host processor hands a command to an embedded controller and collects the outcome. The host sees a 32-bit register bus with an address, a write strobe, byte-lane enables and combinational read data. Through it the host loads two 32-bit pointer words and up to four data words, then writes a single command word. That write marks the mailbox busy and sends the controller a one-cycle doorbell, along with the decoded fields of the command.

The controller works through the command, places any reply words in a read buffer, and reports completion with an error flag and an 8-bit error code. The completion clears busy. Bit 8 of the command word selects how the host learns that the command is done. When the bit is set, the host gets a one-cycle completion pulse. When it is clear, the host polls the busy bit in the status word. While a command is outstanding, further command writes are ignored, so the controller always sees stable command fields.

Error codes 0 to 7 are conventionally read as: none, unsupported, not serviced, cannot service, invalid, failed, and two security rejections. The mailbox only carries the code and does not interpret it.

Top module: `mbx_top`

## Requirements
- R1: After reset every register reads zero: busy clear, error clear, code zero, pointers zero, both buffers zero. The doorbell and the host interrupt are low.
- R2: A host write to offset 0x00 while idle latches the command fields. The fields are code [7:0], interrupt flag [8], sub-type [15:12] and size [23:16]. The write sets busy and clears the error bit and the error code. The doorbell is high for exactly the one cycle after the write edge.
- R3: A host write to offset 0x00 while busy is ignored. The latched fields stay unchanged and no doorbell pulse is produced.
- R4: Status at offset 0x04 packs the following fields, with bits 3:2 and 31:24 reading zero:
  - busy in bit 0
  - error in bit 1
  - sub-type in bits 7:4
  - the INITIATOR_ID parameter (default 0x01) in bits 15:8
  - the error code in bits 23:16
- R5: A controller completion (c_done) while busy clears busy on that edge and captures c_err and c_code. A completion while idle changes nothing.
- R6: A completion of a command whose flag bit 8 was set drives host_irq high for exactly the one cycle after the completion edge. A completion with the flag clear drives no pulse.
- R7: The write buffer at offsets 0x80 to 0x8F stores a host write only when all four byte enables are set. Partial writes are dropped. Each word is presented to the controller on c_wbuf, with word n at bits 32n+31:32n.
- R8: The source pointer at 0x08 and the destination pointer at 0x0C take host writes per enabled byte lane. Both are readable at their offsets and are presented to the controller.
- R9: The controller writes whole words into the read buffer (c_rb_we, c_rb_idx). The host reads the buffer at 0x90 to 0x9F. With h_be = 4'hF the read returns the whole word. With any other h_be it returns the byte selected by h_addr[1:0], zero-extended in bits 7:0.
- R10: Reads of offset 0x00, of the write buffer and of unmapped offsets return zero. Host writes to the status word and to the read buffer are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_addr | input | AW | Host byte address |
| h_we | input | 1 | Host write strobe |
| h_be | input | 4 | Host byte-lane enables (writes; byte select on read buffer) |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for h_addr, combinational |
| host_irq | output | 1 | One-cycle completion pulse to the host |
| c_doorbell | output | 1 | One-cycle new-command pulse to the controller |
| c_cmd_code | output | 8 | Latched command code |
| c_cmd_sub | output | 4 | Latched command sub-type |
| c_cmd_size | output | 8 | Latched payload size in bytes |
| c_cmd_ioc | output | 1 | Latched interrupt-on-completion flag |
| c_src_ptr | output | 32 | Source pointer word |
| c_dst_ptr | output | 32 | Destination pointer word |
| c_wbuf | output | 32*BUF_WORDS | Write buffer contents |
| c_rb_we | input | 1 | Controller read-buffer write strobe |
| c_rb_idx | input | $clog2(BUF_WORDS) | Read-buffer word index |
| c_rb_data | input | 32 | Read-buffer word data |
| c_done | input | 1 | Command completion strobe |
| c_err | input | 1 | Error flag sampled with c_done |
| c_code | input | 8 | Error code sampled with c_done |

## Verification
A corrupted busy flag appears on the next status read. A stuck-busy flag blocks the following command, so no doorbell follows its write. A spurious busy clear lets a second command overwrite the fields the controller is still using within one cycle. Errors in the latched command or in the completion capture reach the ports within one cycle, either as wrong c_cmd_* values or as a wrong host_irq pulse (missing, doubled or unrequested). A misdecoded offset or byte-enable rule shows on the next read-back of the pointers or the read buffer, or on c_wbuf in the cycle after the write. The bench compares all of these against a behavioural model on every clock.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;

  // Host-visible offsets (byte addresses)
  localparam logic [7:0] OFS_CMD  = 8'h00;
  localparam logic [7:0] OFS_STS  = 8'h04;
  localparam logic [7:0] OFS_SRC  = 8'h08;
  localparam logic [7:0] OFS_DST  = 8'h0C;
  localparam logic [7:0] OFS_WBUF = 8'h80;
  localparam logic [7:0] OFS_RBUF = 8'h90;

  typedef struct packed {
    logic [7:0] size;
    logic [3:0] sub;
    logic       ioc;
    logic [7:0] code;
  } cmd_t;

  // Field positions of the command word
  function automatic cmd_t cmd_unpack(input logic [31:0] w);
    cmd_t c;
    c.size = w[23:16];
    c.sub  = w[15:12];
    c.ioc  = w[8];
    c.code = w[7:0];
    return c;
  endfunction

  // Status word layout
  function automatic logic [31:0] sts_pack(input logic busy, input logic err,
                                           input logic [3:0] sub,
                                           input logic [7:0] init_id,
                                           input logic [7:0] code);
    return {8'h00, code, init_id, sub, 2'b00, err, busy};
  endfunction

  function automatic logic [7:0] byte_pick(input logic [31:0] w, input logic [1:0] sel);
    return w[8*sel +: 8];
  endfunction

  function automatic logic in_window(input logic [7:0] a, input logic [7:0] base,
                                     input int unsigned words);
    return (int'(a) >= int'(base)) && (int'(a) < int'(base) + 4 * int'(words));
  endfunction

endpackage

// File: rtl/mbx_core.sv
`timescale 1ns/1ps
module mbx_core
  import mbx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_accept,
  input  logic [31:0] cmd_word,
  input  logic        done_take,
  input  logic        done_err,
  input  logic [7:0]  done_code,
  output logic        busy,
  output logic        err_q,
  output logic [7:0]  code_q,
  output cmd_t        cmd_q,
  output logic        doorbell,
  output logic        irq
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      err_q    <= 1'b0;
      code_q   <= '0;
      cmd_q    <= '0;
      doorbell <= 1'b0;
      irq      <= 1'b0;
    end else begin
      doorbell <= cmd_accept;
      irq      <= done_take & cmd_q.ioc;
      if (cmd_accept) begin
        cmd_q  <= cmd_unpack(cmd_word);
        busy   <= 1'b1;
        err_q  <= 1'b0;
        code_q <= '0;
      end else if (done_take) begin
        busy   <= 1'b0;
        err_q  <= done_err;
        code_q <= done_code;
      end
    end
  end

endmodule

// File: rtl/mbx_bereg.sv
`timescale 1ns/1ps
module mbx_bereg #(
  parameter int LANES = 4,
  localparam int W = 8 * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [LANES-1:0] be,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     q
);

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        lane_q <= '0;
      else if (we && be[b])
        lane_q <= wdata[8*b +: 8];
    end
    assign q[8*b +: 8] = lane_q;
  end

endmodule

// File: rtl/mbx_wbuf.sv
`timescale 1ns/1ps
module mbx_wbuf #(
  parameter int WORDS = 4,
  localparam int IW = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [IW-1:0]       idx,
  input  logic [3:0]          be,
  input  logic [31:0]         wdata,
  output logic [32*WORDS-1:0] flat
);

  logic full_word;
  assign full_word = (be == 4'hF);

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [31:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        word_q <= '0;
      else if (we && full_word && (idx == IW'(w)))
        word_q <= wdata;
    end
    assign flat[32*w +: 32] = word_q;
  end

endmodule

// File: rtl/mbx_rbuf.sv
`timescale 1ns/1ps
module mbx_rbuf
  import mbx_pkg::*;
#(
  parameter int WORDS = 4,
  localparam int IW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          c_we,
  input  logic [IW-1:0] c_idx,
  input  logic [31:0]   c_data,
  input  logic [IW-1:0] rd_idx,
  input  logic [1:0]    rd_sel,
  input  logic          rd_byte,
  output logic [31:0]   rd_data
);

  logic [31:0] words [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [31:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        word_q <= '0;
      else if (c_we && (c_idx == IW'(w)))
        word_q <= c_data;
    end
    assign words[w] = word_q;
  end

  logic [31:0] sel_word;
  assign sel_word = words[rd_idx];
  assign rd_data  = rd_byte ? {24'h0, byte_pick(sel_word, rd_sel)} : sel_word;

endmodule

// File: rtl/mbx_top.sv
`timescale 1ns/1ps
module mbx_top
  import mbx_pkg::*;
#(
  parameter int         AW           = 8,
  parameter int         BUF_WORDS    = 4,
  parameter logic [7:0] INITIATOR_ID = 8'h01
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [AW-1:0]                 h_addr,
  input  logic                          h_we,
  input  logic [3:0]                    h_be,
  input  logic [31:0]                   h_wdata,
  output logic [31:0]                   h_rdata,
  output logic                          host_irq,
  output logic                          c_doorbell,
  output logic [7:0]                    c_cmd_code,
  output logic [3:0]                    c_cmd_sub,
  output logic [7:0]                    c_cmd_size,
  output logic                          c_cmd_ioc,
  output logic [31:0]                   c_src_ptr,
  output logic [31:0]                   c_dst_ptr,
  output logic [32*BUF_WORDS-1:0]       c_wbuf,
  input  logic                          c_rb_we,
  input  logic [$clog2(BUF_WORDS)-1:0]  c_rb_idx,
  input  logic [31:0]                   c_rb_data,
  input  logic                          c_done,
  input  logic                          c_err,
  input  logic [7:0]                    c_code
);

  localparam int IW = $clog2(BUF_WORDS);

  // Address decode (low 8 bits carry the offset)
  logic [7:0] ofs;
  logic       hi_zero;
  assign ofs     = h_addr[7:0];
  assign hi_zero = (h_addr >> 8) == '0;

  logic sel_cmd, sel_sts, sel_src, sel_dst, sel_wbuf, sel_rbuf;
  assign sel_cmd  = hi_zero && (ofs == OFS_CMD);
  assign sel_sts  = hi_zero && (ofs == OFS_STS);
  assign sel_src  = hi_zero && (ofs == OFS_SRC);
  assign sel_dst  = hi_zero && (ofs == OFS_DST);
  assign sel_wbuf = hi_zero && in_window(ofs, OFS_WBUF, BUF_WORDS);
  assign sel_rbuf = hi_zero && in_window(ofs, OFS_RBUF, BUF_WORDS);

  logic [IW-1:0] word_idx;
  assign word_idx = ofs[IW+1:2];

  // Named events for the checker
  logic busy;
  logic cmd_accept;
  logic done_take;
  assign cmd_accept = h_we && sel_cmd && !busy;
  assign done_take  = c_done && busy;

  logic       err_q;
  logic [7:0] code_q;
  cmd_t       cmd_q;

  mbx_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_accept (cmd_accept),
    .cmd_word   (h_wdata),
    .done_take  (done_take),
    .done_err   (c_err),
    .done_code  (c_code),
    .busy       (busy),
    .err_q      (err_q),
    .code_q     (code_q),
    .cmd_q      (cmd_q),
    .doorbell   (c_doorbell),
    .irq        (host_irq)
  );

  assign c_cmd_code = cmd_q.code;
  assign c_cmd_sub  = cmd_q.sub;
  assign c_cmd_size = cmd_q.size;
  assign c_cmd_ioc  = cmd_q.ioc;

  mbx_bereg #(.LANES(4)) u_src (
    .clk (clk), .rst_n (rst_n), .we (h_we && sel_src), .be (h_be),
    .wdata (h_wdata), .q (c_src_ptr)
  );

  mbx_bereg #(.LANES(4)) u_dst (
    .clk (clk), .rst_n (rst_n), .we (h_we && sel_dst), .be (h_be),
    .wdata (h_wdata), .q (c_dst_ptr)
  );

  mbx_wbuf #(.WORDS(BUF_WORDS)) u_wbuf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (h_we && sel_wbuf),
    .idx   (word_idx),
    .be    (h_be),
    .wdata (h_wdata),
    .flat  (c_wbuf)
  );

  logic [31:0] rbuf_rd;
  mbx_rbuf #(.WORDS(BUF_WORDS)) u_rbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .c_we    (c_rb_we),
    .c_idx   (c_rb_idx),
    .c_data  (c_rb_data),
    .rd_idx  (word_idx),
    .rd_sel  (ofs[1:0]),
    .rd_byte (h_be != 4'hF),
    .rd_data (rbuf_rd)
  );

  // Read mux: write-only and unmapped offsets return zero
  always_comb begin
    h_rdata = '0;
    if (sel_sts)
      h_rdata = sts_pack(busy, err_q, cmd_q.sub, INITIATOR_ID, code_q);
    else if (sel_src)
      h_rdata = c_src_ptr;
    else if (sel_dst)
      h_rdata = c_dst_ptr;
    else if (sel_rbuf)
      h_rdata = rbuf_rd;
  end

endmodule

// File: rtl/mbx_checker.sv
`timescale 1ns/1ps
module mbx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_accept,
  input logic       done_take,
  input logic       busy,
  input logic       doorbell,
  input logic       host_irq,
  input logic [7:0] cmd_code,
  input logic [3:0] cmd_sub,
  input logic [7:0] cmd_size,
  input logic       cmd_ioc
);

  // R2: doorbell only follows an accepted command write
  assert_doorbell_follows_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |-> $past(cmd_accept));

  // R2: busy rises together with the doorbell
  assert_busy_rise_rings_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> doorbell);

  // R3: command fields hold while a command is outstanding
  assert_fields_held_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(cmd_code) && $stable(cmd_sub) &&
                               $stable(cmd_size) && $stable(cmd_ioc)));

  // R5: busy only drops after a taken completion
  assert_busy_fall_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done_take));

  // R6: host pulse only at completion of a flagged command
  assert_irq_on_flagged_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> ($fell(busy) && cmd_ioc));

  // R6: no pulse for an unflagged completion
  assert_no_irq_unflagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !cmd_ioc) |-> !host_irq);

  // R6: pulse lasts one cycle
  assert_irq_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |=> !host_irq);

endmodule

bind mbx_top mbx_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_accept (cmd_accept),
  .done_take  (done_take),
  .busy       (busy),
  .doorbell   (c_doorbell),
  .host_irq   (host_irq),
  .cmd_code   (c_cmd_code),
  .cmd_sub    (c_cmd_sub),
  .cmd_size   (c_cmd_size),
  .cmd_ioc    (c_cmd_ioc)
);

// File: tb/mbx_top_test.sv
`timescale 1ns/1ps
module mbx_top_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   h_addr = '0;
  logic         h_we = 1'b0;
  logic [3:0]   h_be = 4'hF;
  logic [31:0]  h_wdata = '0;
  logic [31:0]  h_rdata;
  logic         host_irq, c_doorbell, c_cmd_ioc;
  logic [7:0]   c_cmd_code, c_cmd_size;
  logic [3:0]   c_cmd_sub;
  logic [31:0]  c_src_ptr, c_dst_ptr;
  logic [127:0] c_wbuf;
  logic         c_rb_we = 1'b0;
  logic [1:0]   c_rb_idx = '0;
  logic [31:0]  c_rb_data = '0;
  logic         c_done = 1'b0, c_err = 1'b0;
  logic [7:0]   c_code = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  mbx_top uut (
    .clk (clk), .rst_n (rst_n), .h_addr (h_addr), .h_we (h_we), .h_be (h_be),
    .h_wdata (h_wdata), .h_rdata (h_rdata), .host_irq (host_irq),
    .c_doorbell (c_doorbell), .c_cmd_code (c_cmd_code), .c_cmd_sub (c_cmd_sub),
    .c_cmd_size (c_cmd_size), .c_cmd_ioc (c_cmd_ioc), .c_src_ptr (c_src_ptr),
    .c_dst_ptr (c_dst_ptr), .c_wbuf (c_wbuf), .c_rb_we (c_rb_we),
    .c_rb_idx (c_rb_idx), .c_rb_data (c_rb_data), .c_done (c_done),
    .c_err (c_err), .c_code (c_code)
  );

  // ---------------- behavioural reference model ----------------
  bit        m_busy, m_err, m_ioc, m_door, m_irq;
  bit [7:0]  m_ecode, m_code, m_size;
  bit [3:0]  m_sub;
  bit [31:0] m_src, m_dst;
  bit [31:0] m_wb [4];
  bit [31:0] m_rb [4];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_err = 0; m_ioc = 0; m_door = 0; m_irq = 0;
      m_ecode = 0; m_code = 0; m_size = 0; m_sub = 0; m_src = 0; m_dst = 0;
      for (int i = 0; i < 4; i++) begin m_wb[i] = 0; m_rb[i] = 0; end
    end else begin
      bit take_cmd, take_done;
      take_cmd  = h_we && h_addr == 8'h00 && !m_busy;
      take_done = c_done && m_busy;
      m_door = take_cmd;
      m_irq  = take_done && m_ioc;
      if (take_cmd) begin
        m_code = h_wdata[7:0]; m_ioc = h_wdata[8];
        m_sub = h_wdata[15:12]; m_size = h_wdata[23:16];
        m_busy = 1; m_err = 0; m_ecode = 0;
      end else if (take_done) begin
        m_busy = 0; m_err = c_err; m_ecode = c_code;
      end
      for (int b = 0; b < 4; b++) begin
        if (h_we && h_be[b] && h_addr == 8'h08) m_src[8*b +: 8] = h_wdata[8*b +: 8];
        if (h_we && h_be[b] && h_addr == 8'h0C) m_dst[8*b +: 8] = h_wdata[8*b +: 8];
      end
      if (h_we && h_be == 4'hF && h_addr >= 8'h80 && h_addr <= 8'h8F)
        m_wb[h_addr[3:2]] = h_wdata;
      if (c_rb_we) m_rb[c_rb_idx] = c_rb_data;
    end
  end

  function automatic bit [31:0] m_read(bit [7:0] a, bit [3:0] be);
    bit [31:0] w;
    if (a == 8'h04) return {8'h00, m_ecode, 8'h01, m_sub, 2'b00, m_err, m_busy};
    if (a == 8'h08) return m_src;
    if (a == 8'h0C) return m_dst;
    if (a >= 8'h90 && a <= 8'h9F) begin
      w = m_rb[a[3:2]];
      if (be == 4'hF) return w;
      return (w >> (8 * a[1:0])) & 32'hFF;
    end
    return 32'h0;
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2 R3 model doorbell/fields",
          {c_doorbell, c_cmd_code, c_cmd_sub, c_cmd_size, c_cmd_ioc},
          {m_door, m_code, m_sub, m_size, m_ioc});
      chk("R6 model host_irq", host_irq, m_irq);
      chk("R8 model pointers", {c_src_ptr, c_dst_ptr}, {m_src, m_dst});
      chk("R7 model wbuf", c_wbuf, {m_wb[3], m_wb[2], m_wb[1], m_wb[0]});
      chk("R4 R9 R10 model read", h_rdata, m_read(h_addr, h_be));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic hwrite(bit [7:0] a, bit [31:0] d, bit [3:0] be);
    h_addr = a; h_wdata = d; h_be = be; h_we = 1;
    @(posedge clk); #1;
    h_we = 0; h_be = 4'hF;
  endtask

  task automatic hread(bit [7:0] a, bit [3:0] be, bit [31:0] exp, string tag);
    h_addr = a; h_be = be;
    #1 chk(tag, h_rdata, exp);
    h_be = 4'hF;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic complete(bit e, bit [7:0] code);
    c_done = 1; c_err = e; c_code = code;
    @(posedge clk); #1;
    c_done = 0; c_err = 0; c_code = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    hread(8'h04, 4'hF, 32'h0000_0100, "R1 status after reset");
    chk("R1 doorbell/irq low", {c_doorbell, host_irq}, 2'b00);
    chk("R1 buffers zero", c_wbuf, '0);
    hread(8'h08, 4'hF, 32'h0, "R1 src pointer zero");

    // R8 pointers with byte lanes
    hwrite(8'h08, 32'h1122_3344, 4'hF);
    hwrite(8'h08, 32'hAABB_CCDD, 4'b0010);
    hread(8'h08, 4'hF, 32'h1122_CC44, "R8 src lane merge");
    hwrite(8'h0C, 32'h5566_7788, 4'b1001);
    hread(8'h0C, 4'hF, 32'h5500_0088, "R8 dst lane merge");

    // R7 write buffer
    hwrite(8'h80, 32'hDEAD_BEEF, 4'hF);
    hwrite(8'h84, 32'h0102_0304, 4'hF);
    hwrite(8'h84, 32'hFFFF_FFFF, 4'b0011);
    chk("R7 partial write dropped", c_wbuf[63:0], 64'h0102_0304_DEAD_BEEF);
    hwrite(8'h8C, 32'hCAFE_F00D, 4'hF);
    chk("R7 word 3 stored", c_wbuf[127:96], 32'hCAFE_F00D);
    hread(8'h80, 4'hF, 32'h0, "R10 wbuf reads zero");

    // R2 command without interrupt flag
    hwrite(8'h00, 32'h0008_503C, 4'hF);
    chk("R2 doorbell pulse", c_doorbell, 1'b1);
    chk("R2 fields", {c_cmd_code, c_cmd_sub, c_cmd_size, c_cmd_ioc},
        {8'h3C, 4'h5, 8'h08, 1'b0});
    hread(8'h04, 4'hF, 32'h0000_0151, "R4 status busy");
    idle(1);
    chk("R2 doorbell one cycle", c_doorbell, 1'b0);
    hread(8'h00, 4'hF, 32'h0, "R10 command reads zero");

    // R3 command while busy
    hwrite(8'h00, 32'h00FF_F1AA, 4'hF);
    chk("R3 no doorbell while busy", c_doorbell, 1'b0);
    chk("R3 fields held", {c_cmd_code, c_cmd_sub, c_cmd_size, c_cmd_ioc},
        {8'h3C, 4'h5, 8'h08, 1'b0});

    // R9 read buffer fill and byte reads
    c_rb_we = 1; c_rb_idx = 2; c_rb_data = 32'hA1B2_C3D4;
    @(posedge clk); #1 c_rb_we = 0;
    hread(8'h98, 4'hF, 32'hA1B2_C3D4, "R9 word read");
    hread(8'h9A, 4'b0100, 32'h0000_00B2, "R9 byte read");
    hread(8'h9B, 4'b0001, 32'h0000_00A1, "R9 top byte read");
    hwrite(8'h98, 32'h0, 4'hF);
    hread(8'h98, 4'hF, 32'hA1B2_C3D4, "R10 rbuf host write ignored");
    hwrite(8'h04, 32'hFFFF_FFFF, 4'hF);
    hread(8'h04, 4'hF, 32'h0000_0151, "R10 status write ignored");

    // R5 completion with error, no flag
    complete(1'b1, 8'h05);
    hread(8'h04, 4'hF, 32'h0005_0152, "R5 status after error completion");
    chk("R6 no irq unflagged", host_irq, 1'b0);
    idle(1);
    chk("R6 still no irq", host_irq, 1'b0);
    complete(1'b0, 8'h07);
    hread(8'h04, 4'hF, 32'h0005_0152, "R5 idle completion ignored");

    // R6 flagged command
    hwrite(8'h00, 32'h0004_2107, 4'hF);
    hread(8'h04, 4'hF, 32'h0000_0121, "R2 error cleared on new command");
    idle(2);
    chk("R6 no early irq", host_irq, 1'b0);
    complete(1'b0, 8'h00);
    chk("R6 irq pulse", host_irq, 1'b1);
    hread(8'h04, 4'hF, 32'h0000_0120, "R5 busy cleared");
    idle(1);
    chk("R6 irq one cycle", host_irq, 1'b0);

    // R10 unmapped offset
    hread(8'h40, 4'hF, 32'h0, "R10 unmapped reads zero");
    idle(3);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule